// File: doc/BRIEF.md
# ECC Error Capture Logger

This block watches the read path of a cache data store that is guarded by single-correct, double-detect ECC. Each read returns half a cacheline as four 128-bit lanes, and each lane carries a 10-bit check code. For every read, the upstream decoder presents the following to the logger:

- a per-lane single-error indication;
- a per-lane double-error indication;
- the four lane syndromes;
- the half-line index and the set number.

The logger keeps two sticky flags, one for corrected errors and one for uncorrectable errors. It records where the first relevant error happened and raises an interrupt according to two enables.

Capture follows an asymmetric priority, held in a three-state machine:

- `ST_ARMED`: nothing is held, and any error is captured.
- `ST_HELD_SEC`: a single-error record is held. Further single errors are counted only in the flag. A double error overwrites the record.
- `ST_HELD_DED`: a double-error record is held and nothing overwrites it.

The named transitions are:

- ARM_TO_SEC: a single error arrives while armed.
- ARM_TO_DED: a double error arrives while armed.
- SEC_TO_DED: a promotion, where a double error arrives while a single-error record is held.
- SEC_TO_ARM: the single flag is cleared.
- DED_TO_SEC: the double flag is cleared while the single flag is still set.
- DED_TO_ARM: both flags are clear.

Flags are cleared by write-one pulses.

When ECC is turned off, error indications are ignored and the block offers a diagnostic mode. A diagnostic load then copies the raw check bits of one of the two half lines into the syndrome registers, with a select bit choosing which half.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset the two flags, the interrupt, the failing index, set, lane mask and both syndrome registers are all zero, and the machine is in ST_ARMED.
- R2: With ECC on and rd_valid high, a read with any rd_sec bit set and no rd_ded bit set does two things in ST_ARMED. It sets sec_flag on the next cycle. It also captures rd_idx, rd_set, fail_mask = rd_sec, syn_lo = {lane1, lane0} and syn_hi = {lane3, lane2}, where lane k of rd_syn is bits [10k+9:10k].
- R3: With ECC on, a read with any rd_ded bit set does two things in ST_ARMED or ST_HELD_SEC. It sets ded_flag and captures the address, the set and all four syndromes with fail_mask = rd_ded. In ST_HELD_SEC this overwrites the held single-error record.
- R4: A read carrying both single and double lanes sets both flags and captures the double-error record, with the mask taken from rd_ded.
- R5: While a single-error record is held and no double error arrives, further single errors leave the captured index, set, mask and syndromes unchanged.
- R6: While a double-error record is held, no single or double error changes the captured record, though the flags still get set.
- R7: A one on clr_sec clears sec_flag and a one on clr_ded clears ded_flag. A new error of the same kind in the same cycle wins over the clear.
- R8: Once both flags are clear the machine returns to ST_ARMED and the next error is captured again.
- R9: irq is high exactly when (sec_flag and cfg_sec_ie) or (ded_flag and cfg_ded_ie).
- R10: With cfg_ecc_en low, rd_sec and rd_ded are ignored: the flags do not set and the captured record does not change.
- R11: With cfg_ecc_en low and cfg_diag_en high, a diag_load pulse loads raw check bits into syn_lo and syn_hi, where lane k of diag_chk is bits [10k+9:10k] for k = 0..7. With cfg_half_sel = 0 it loads lanes 0..3, and with cfg_half_sel = 1 it loads lanes 4..7. The flags and failing address are untouched. A diag_load pulse with ECC on or with cfg_diag_en low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ecc_en | input | 1 | ECC checking on |
| cfg_sec_ie | input | 1 | Interrupt enable for corrected errors |
| cfg_ded_ie | input | 1 | Interrupt enable for uncorrectable errors |
| cfg_half_sel | input | 1 | Diagnostic half-line select (0 = lanes 0..3, 1 = lanes 4..7) |
| cfg_diag_en | input | 1 | Diagnostic capture allowed while ECC is off |
| clr_sec | input | 1 | Write-one clear of sec_flag |
| clr_ded | input | 1 | Write-one clear of ded_flag |
| rd_valid | input | 1 | A read result is present this cycle |
| rd_sec | input | 4 | Per-lane single-error (corrected) indication |
| rd_ded | input | 4 | Per-lane double-error indication |
| rd_syn | input | 40 | Four 10-bit lane syndromes, lane k at [10k+9:10k] |
| rd_idx | input | 11 | Half-cacheline index of the read |
| rd_set | input | 3 | Set number of the read |
| diag_load | input | 1 | Diagnostic load strobe |
| diag_chk | input | 80 | Raw check bits of eight lanes, lane k at [10k+9:10k] |
| sec_flag | output | 1 | Sticky corrected-error flag |
| ded_flag | output | 1 | Sticky uncorrectable-error flag |
| fail_idx | output | 11 | Captured half-cacheline index |
| fail_set | output | 3 | Captured set number |
| fail_mask | output | 4 | Captured lane mask |
| syn_lo | output | 20 | Captured syndromes or check bits of lanes 0 and 1 |
| syn_hi | output | 20 | Captured syndromes or check bits of lanes 2 and 3 |
| irq | output | 1 | Error interrupt |

## Verification
The bench sweeps every pair of single and double lane masks. It does this twice from the armed state: first as a lone read, then as a second read on top of the record the first one left. This covers the promotion, both hold rules and the same-cycle case, each against a model in the bench.

A design that let a single error overwrite a held record would show a changed mask or syndrome after the second read. A design that took the mask from the wrong vector on a mixed read would report single lanes as the failing ones.

Directed runs cover three further cases:

- A clear pulse that coincides with a new error, where a clear-first design would drop the flag.
- All four interrupt-enable combinations.
- Both diagnostic half selects, plus diagnostic loads made while ECC is on, where a design that skipped the gate would overwrite the syndromes.

// File: rtl/ecl_pkg.sv
package ecl_pkg;

    // Capture lock states of the logger.
    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_HELD_SEC = 2'd1,
        ST_HELD_DED = 2'd2
    } ecl_state_e;

endpackage

// File: rtl/ecl_event_decode.sv
// Gates per-lane error indications with read-valid and ECC enable and
// reduces them to event strobes.
module ecl_event_decode #(
    parameter int LANES = 4
) (
    input  logic             rd_valid,
    input  logic             ecc_en,
    input  logic [LANES-1:0] lane_sec,
    input  logic [LANES-1:0] lane_ded,
    output logic [LANES-1:0] sec_mask,
    output logic [LANES-1:0] ded_mask,
    output logic             sec_hit,
    output logic             ded_hit
);
    logic qualify;
    assign qualify = rd_valid & ecc_en;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign sec_mask[k] = qualify & lane_sec[k];
        assign ded_mask[k] = qualify & lane_ded[k];
    end

    assign sec_hit = |sec_mask;
    assign ded_hit = |ded_mask;
endmodule

// File: rtl/ecl_diag_select.sv
// Picks one half line of raw check bits out of a full line.
module ecl_diag_select #(
    parameter int LANES = 4,
    parameter int SYN_W = 10
) (
    input  logic                     half_sel,
    input  logic [2*LANES*SYN_W-1:0] chk_line,
    output logic [LANES*SYN_W-1:0]   chk_half
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign chk_half[k*SYN_W +: SYN_W] = half_sel
            ? chk_line[(k+LANES)*SYN_W +: SYN_W]
            : chk_line[k*SYN_W +: SYN_W];
    end
endmodule

// File: rtl/ecl_capture_bank.sv
// Holds the failing-address record and the syndrome words.
module ecl_capture_bank #(
    parameter int LANES = 4,
    parameter int SYN_W = 10,
    parameter int IDX_W = 11,
    parameter int SET_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_fault,
    input  logic                   load_diag,
    input  logic [IDX_W-1:0]       in_idx,
    input  logic [SET_W-1:0]       in_set,
    input  logic [LANES-1:0]       in_mask,
    input  logic [LANES*SYN_W-1:0] in_syn,
    input  logic [LANES*SYN_W-1:0] in_chk,
    output logic [IDX_W-1:0]       q_idx,
    output logic [SET_W-1:0]       q_set,
    output logic [LANES-1:0]       q_mask,
    output logic [LANES*SYN_W-1:0] q_syn
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_idx  <= '0;
            q_set  <= '0;
            q_mask <= '0;
        end else if (load_fault) begin
            q_idx  <= in_idx;
            q_set  <= in_set;
            q_mask <= in_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_syn <= '0;
        end else if (load_fault) begin
            q_syn <= in_syn;
        end else if (load_diag) begin
            q_syn <= in_chk;
        end
    end
endmodule

// File: rtl/ecc_err_logger.sv
// ECC error capture logger: sticky flags, asymmetric capture priority,
// diagnostic raw check-bit capture.
module ecc_err_logger
    import ecl_pkg::*;
#(
    parameter int LANES = 4,
    parameter int SYN_W = 10,
    parameter int IDX_W = 11,
    parameter int SET_W = 3,
    localparam int SYN_ALL = LANES * SYN_W,
    localparam int HALF_W  = SYN_ALL / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_ecc_en,
    input  logic                 cfg_sec_ie,
    input  logic                 cfg_ded_ie,
    input  logic                 cfg_half_sel,
    input  logic                 cfg_diag_en,
    input  logic                 clr_sec,
    input  logic                 clr_ded,
    input  logic                 rd_valid,
    input  logic [LANES-1:0]     rd_sec,
    input  logic [LANES-1:0]     rd_ded,
    input  logic [SYN_ALL-1:0]   rd_syn,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [SET_W-1:0]     rd_set,
    input  logic                 diag_load,
    input  logic [2*SYN_ALL-1:0] diag_chk,
    output logic                 sec_flag,
    output logic                 ded_flag,
    output logic [IDX_W-1:0]     fail_idx,
    output logic [SET_W-1:0]     fail_set,
    output logic [LANES-1:0]     fail_mask,
    output logic [HALF_W-1:0]    syn_lo,
    output logic [HALF_W-1:0]    syn_hi,
    output logic                 irq
);
    ecl_state_e state_q, state_d;

    logic [LANES-1:0]   sec_mask, ded_mask;
    logic               sec_hit, ded_hit;
    logic [SYN_ALL-1:0] chk_half;
    logic [SYN_ALL-1:0] syn_q;
    logic               sec_q, ded_q, sec_d, ded_d;
    logic               cap_fault, cap_diag;
    logic [LANES-1:0]   cap_mask;

    ecl_event_decode #(.LANES(LANES)) u_decode (
        .rd_valid (rd_valid),
        .ecc_en   (cfg_ecc_en),
        .lane_sec (rd_sec),
        .lane_ded (rd_ded),
        .sec_mask (sec_mask),
        .ded_mask (ded_mask),
        .sec_hit  (sec_hit),
        .ded_hit  (ded_hit)
    );

    ecl_diag_select #(.LANES(LANES), .SYN_W(SYN_W)) u_diag (
        .half_sel (cfg_half_sel),
        .chk_line (diag_chk),
        .chk_half (chk_half)
    );

    // Sticky flags: a new event of a kind beats a clear of that kind.
    assign sec_d = (sec_q & ~clr_sec) | sec_hit;
    assign ded_d = (ded_q & ~clr_ded) | ded_hit;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            sec_q   <= 1'b0;
            ded_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sec_q   <= sec_d;
            ded_q   <= ded_d;
        end
    end

    // Next state and capture decision.
    always_comb begin
        state_d   = state_q;
        cap_fault = 1'b0;
        cap_mask  = sec_mask;
        unique case (state_q)
            ST_ARMED: begin
                if (ded_hit) begin            // ARM_TO_DED
                    cap_fault = 1'b1;
                    cap_mask  = ded_mask;
                    state_d   = ST_HELD_DED;
                end else if (sec_hit) begin   // ARM_TO_SEC
                    cap_fault = 1'b1;
                    cap_mask  = sec_mask;
                    state_d   = ST_HELD_SEC;
                end
            end
            ST_HELD_SEC: begin
                if (ded_hit) begin            // SEC_TO_DED
                    cap_fault = 1'b1;
                    cap_mask  = ded_mask;
                    state_d   = ST_HELD_DED;
                end else if (!sec_d) begin    // SEC_TO_ARM
                    state_d   = ST_ARMED;
                end
            end
            ST_HELD_DED: begin
                if (!ded_d) begin             // DED_TO_SEC / DED_TO_ARM
                    state_d = sec_d ? ST_HELD_SEC : ST_ARMED;
                end
            end
            default: state_d = ST_ARMED;
        endcase
    end

    assign cap_diag = ~cfg_ecc_en & cfg_diag_en & diag_load;

    ecl_capture_bank #(
        .LANES(LANES), .SYN_W(SYN_W), .IDX_W(IDX_W), .SET_W(SET_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_fault (cap_fault),
        .load_diag  (cap_diag),
        .in_idx     (rd_idx),
        .in_set     (rd_set),
        .in_mask    (cap_mask),
        .in_syn     (rd_syn),
        .in_chk     (chk_half),
        .q_idx      (fail_idx),
        .q_set      (fail_set),
        .q_mask     (fail_mask),
        .q_syn      (syn_q)
    );

    // Outputs.
    always_comb begin
        sec_flag = sec_q;
        ded_flag = ded_q;
        syn_lo   = syn_q[HALF_W-1:0];
        syn_hi   = syn_q[SYN_ALL-1:HALF_W];
        irq      = (sec_q & cfg_sec_ie) | (ded_q & cfg_ded_ie);
    end
endmodule

// File: rtl/ecl_checker.sv
module ecl_checker #(
    parameter int LANES = 4,
    parameter int IDX_W = 11,
    parameter int SET_W = 3,
    parameter int HALF_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_ecc_en,
    input logic              rd_valid,
    input logic [LANES-1:0]  rd_sec,
    input logic [LANES-1:0]  rd_ded,
    input logic              sec_flag,
    input logic              ded_flag,
    input logic [IDX_W-1:0]  fail_idx,
    input logic [SET_W-1:0]  fail_set,
    input logic [LANES-1:0]  fail_mask,
    input logic [HALF_W-1:0] syn_lo,
    input logic              irq
);
    assert_sec_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && cfg_ecc_en && (|rd_sec)) |=> sec_flag);

    assert_ded_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && cfg_ecc_en && (|rd_ded)) |=> ded_flag);

    assert_sec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_flag && !ded_flag && !(rd_valid && cfg_ecc_en && (|rd_ded)))
        |=> ($stable(fail_mask) && $stable(fail_idx) && $stable(fail_set)));

    assert_ded_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ded_flag |=> ($stable(fail_mask) && $stable(fail_idx)
                      && $stable(fail_set) && $stable(syn_lo)));

    assert_quiet_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_flag && !ded_flag) |-> !irq);

    assert_ecc_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ecc_en |=> (!$rose(sec_flag) && !$rose(ded_flag)));
endmodule

bind ecc_err_logger ecl_checker #(
    .LANES(LANES), .IDX_W(IDX_W), .SET_W(SET_W), .HALF_W(HALF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_ecc_en (cfg_ecc_en),
    .rd_valid   (rd_valid),
    .rd_sec     (rd_sec),
    .rd_ded     (rd_ded),
    .sec_flag   (sec_flag),
    .ded_flag   (ded_flag),
    .fail_idx   (fail_idx),
    .fail_set   (fail_set),
    .fail_mask  (fail_mask),
    .syn_lo     (syn_lo),
    .irq        (irq)
);

// File: tb/ecc_err_logger_tb.sv
`timescale 1ns/1ps
module ecc_err_logger_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_ecc_en, cfg_sec_ie, cfg_ded_ie, cfg_half_sel, cfg_diag_en;
    logic        clr_sec, clr_ded, rd_valid, diag_load;
    logic [3:0]  rd_sec, rd_ded;
    logic [39:0] rd_syn;
    logic [10:0] rd_idx;
    logic [2:0]  rd_set;
    logic [79:0] diag_chk;
    logic        sec_flag, ded_flag, irq;
    logic [10:0] fail_idx;
    logic [2:0]  fail_set;
    logic [3:0]  fail_mask;
    logic [19:0] syn_lo, syn_hi;

    int checks = 0;
    int errors = 0;

    // Bench model, written from the requirements.
    logic        m_sec, m_ded;
    logic [10:0] m_idx;
    logic [2:0]  m_set;
    logic [3:0]  m_mask;
    logic [19:0] m_lo, m_hi;

    always #2.5 clk = ~clk;

    ecc_err_logger u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ecc_en(cfg_ecc_en),
        .cfg_sec_ie(cfg_sec_ie), .cfg_ded_ie(cfg_ded_ie),
        .cfg_half_sel(cfg_half_sel), .cfg_diag_en(cfg_diag_en),
        .clr_sec(clr_sec), .clr_ded(clr_ded), .rd_valid(rd_valid),
        .rd_sec(rd_sec), .rd_ded(rd_ded), .rd_syn(rd_syn),
        .rd_idx(rd_idx), .rd_set(rd_set), .diag_load(diag_load),
        .diag_chk(diag_chk), .sec_flag(sec_flag), .ded_flag(ded_flag),
        .fail_idx(fail_idx), .fail_set(fail_set), .fail_mask(fail_mask),
        .syn_lo(syn_lo), .syn_hi(syn_hi), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " sec_flag"},  64'(sec_flag),  64'(m_sec));
        chk({tag, " ded_flag"},  64'(ded_flag),  64'(m_ded));
        chk({tag, " fail_idx"},  64'(fail_idx),  64'(m_idx));
        chk({tag, " fail_set"},  64'(fail_set),  64'(m_set));
        chk({tag, " fail_mask"}, 64'(fail_mask), 64'(m_mask));
        chk({tag, " syn_lo"},    64'(syn_lo),    64'(m_lo));
        chk({tag, " syn_hi"},    64'(syn_hi),    64'(m_hi));
        chk({tag, " irq R9"},    64'(irq),
            64'((m_sec & cfg_sec_ie) | (m_ded & cfg_ded_ie)));
    endtask

    function automatic logic [39:0] mk_syn(input int a, input int b);
        logic [39:0] v;
        for (int k = 0; k < 4; k++) v[k*10 +: 10] = 10'((a*37 + b*11 + k*101 + 5) & 1023);
        return v;
    endfunction

    // One read cycle; the model applies R2, R3, R4, R5, R6, R10.
    task automatic rd(input logic [3:0] s, input logic [3:0] d,
                      input logic [39:0] syn, input logic [10:0] idx, input logic [2:0] st);
        @(negedge clk);
        rd_valid = 1'b1; rd_sec = s; rd_ded = d; rd_syn = syn; rd_idx = idx; rd_set = st;
        @(negedge clk);
        rd_valid = 1'b0; rd_sec = '0; rd_ded = '0;
        if (cfg_ecc_en) begin
            if (d != 0 && !m_ded) begin
                m_idx = idx; m_set = st; m_mask = d; m_lo = syn[19:0]; m_hi = syn[39:20];
            end else if (s != 0 && d == 0 && !m_ded && !m_sec) begin
                m_idx = idx; m_set = st; m_mask = s; m_lo = syn[19:0]; m_hi = syn[39:20];
            end
            if (s != 0) m_sec = 1'b1;
            if (d != 0) m_ded = 1'b1;
        end
    endtask

    task automatic clr(input logic cs, input logic cd);
        @(negedge clk);
        clr_sec = cs; clr_ded = cd;
        @(negedge clk);
        clr_sec = 1'b0; clr_ded = 1'b0;
        if (cs) m_sec = 1'b0;
        if (cd) m_ded = 1'b0;
    endtask

    task automatic dload(input logic half);
        @(negedge clk);
        cfg_half_sel = half; diag_load = 1'b1;
        @(negedge clk);
        diag_load = 1'b0;
        if (!cfg_ecc_en && cfg_diag_en) begin
            m_lo = half ? diag_chk[59:40] : diag_chk[19:0];
            m_hi = half ? diag_chk[79:60] : diag_chk[39:20];
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_ecc_en = 1'b1; cfg_sec_ie = 1'b1; cfg_ded_ie = 1'b1;
        cfg_half_sel = 1'b0; cfg_diag_en = 1'b0;
        clr_sec = 1'b0; clr_ded = 1'b0; rd_valid = 1'b0; diag_load = 1'b0;
        rd_sec = '0; rd_ded = '0; rd_syn = '0; rd_idx = '0; rd_set = '0;
        diag_chk = '0;
        m_sec = 0; m_ded = 0; m_idx = 0; m_set = 0; m_mask = 0; m_lo = 0; m_hi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset");

        // R2 R3 R4 R5 R6 R8: sweep every single/double mask pair, then stack a second read.
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                clr(1'b1, 1'b1);
                rd(4'(i), 4'(j), mk_syn(i, j), 11'(i*97 + j*13), 3'(i + j));
                chk_all("R2 R3 R4 first read");
                rd(4'(j), 4'(i), mk_syn(j, i + 3), 11'(2047 - i*7 - j), 3'(i ^ j));
                chk_all("R3 R5 R6 second read");
            end
        end

        // R7: clear coinciding with a new error of the same kind keeps the flag.
        clr(1'b1, 1'b1);
        rd(4'b0010, 4'b0000, mk_syn(1, 2), 11'h155, 3'd5);
        @(negedge clk);
        rd_valid = 1'b1; rd_sec = 4'b0100; rd_syn = mk_syn(9, 9); clr_sec = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0; rd_sec = '0; clr_sec = 1'b0;
        chk_all("R7 set beats clear");
        clr(1'b1, 1'b0);
        chk_all("R7 clear sec");
        chk({"R8 rearmed"}, 64'(sec_flag | ded_flag), 64'd0);
        rd(4'b1000, 4'b0000, mk_syn(4, 4), 11'h2AA, 3'd2);
        chk_all("R8 capture after rearm");
        // DED clear with SEC still set: promotion must still be possible (R3).
        rd(4'b0000, 4'b0001, mk_syn(5, 6), 11'h011, 3'd1);
        clr(1'b0, 1'b1);
        chk_all("R7 clear ded only");
        rd(4'b0000, 4'b0011, mk_syn(7, 1), 11'h7F0, 3'd6);
        chk_all("R3 overwrite after ded clear");

        // R9: all interrupt-enable combinations with both flags set.
        for (int e = 0; e < 4; e++) begin
            @(negedge clk);
            cfg_sec_ie = e[0]; cfg_ded_ie = e[1];
            clr(1'b1, 1'b1);
            rd(4'b0001, 4'b0000, mk_syn(e, 1), 11'(e), 3'(e));
            chk_all("R9 sec only");
            rd(4'b0000, 4'b0100, mk_syn(e, 2), 11'(e + 8), 3'(e));
            chk_all("R9 sec and ded");
            clr(1'b1, 1'b0);
            chk_all("R9 ded only");
        end
        @(negedge clk);
        cfg_sec_ie = 1'b1; cfg_ded_ie = 1'b1;
        clr(1'b1, 1'b1);

        // R10: ECC off, errors ignored.
        @(negedge clk);
        cfg_ecc_en = 1'b0;
        rd(4'b1111, 4'b1111, mk_syn(3, 3), 11'h3FF, 3'd7);
        chk_all("R10 ecc off ignored");

        // R11: diagnostic capture of both half lines.
        for (int k = 0; k < 8; k++) diag_chk[k*10 +: 10] = 10'(100 + k*77);
        dload(1'b0);
        chk_all("R11 diag disabled ignored");
        @(negedge clk);
        cfg_diag_en = 1'b1;
        dload(1'b0);
        chk_all("R11 diag half 0");
        chk("R11 lane0 raw", 64'(syn_lo[9:0]), 64'(100));
        dload(1'b1);
        chk_all("R11 diag half 1");
        chk("R11 lane7 raw", 64'(syn_hi[19:10]), 64'(100 + 7*77));
        @(negedge clk);
        cfg_ecc_en = 1'b1;
        for (int k = 0; k < 8; k++) diag_chk[k*10 +: 10] = 10'(3 + k);
        dload(1'b0);
        chk_all("R11 diag with ecc on ignored");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule